// File: doc/BRIEF.md
# Write-Once Real-Time Clock Source Selector

This block chooses the timebase for a real-time counter. There are three candidate sources: a slow crystal, a slow on-chip RC oscillator, and a fast crystal brought down by an integer prescaler (meant to land near 1 MHz). Each source reaches the block as a one-cycle tick at the system clock. The block gives back a single registered clock-enable, `rtc_ce`, for the counter logic. Real switching between asynchronous clocks is outside this model and is represented by that enable.

Software uses a two-word register port. The source field can be written once. The first write of a non-zero source code freezes it, and after that only the keep-alive domain reset (`ka_rst`) can clear it. The ordinary system reset (`sys_rst`) leaves the source field, the freeze flag and the prescaler untouched. The prescaler can be rewritten at any time, including after the freeze. A new value is picked up when the divider next reaches terminal count. Prescaler values below 2 silence the fast path.

Top module: `rtc_src_select`

## Requirements
- R1: Register word 0 (`reg_addr`=0) reads back the source code in bits [1:0] and the freeze flag in bit 2, with all other bits 0. Source codes are 0 = none, 1 = slow crystal, 2 = slow RC, 3 = divided fast crystal.
- R2: `rtc_ce` is the tick of the selected source delayed by exactly one clock. With source code 0 it stays 0.
- R3: While unfrozen, a write to word 0 stores bits [1:0]. A non-zero value also sets the freeze flag, and a value of 0 leaves the flag clear.
- R4: While frozen, writes to word 0 change neither the readback nor the source that drives `rtc_ce`.
- R5: `sys_rst` leaves the source code, the freeze flag and the prescaler unchanged.
- R6: `ka_rst` clears the source code, the freeze flag and the prescaler to 0.
- R7: Register word 1 holds the prescaler in bits [4:0]. It is writable and readable whether or not the source is frozen.
- R8: With prescaler N in 2..31 and the divided source selected, `rtc_ce` pulses once per N fast ticks, whether the ticks arrive every cycle or sparsely.
- R9: Prescaler values 0 and 1 produce no pulses. Once the counter has run out, the first fast tick after a valid value is written produces a pulse.
- R10: A prescaler change made part-way through a period does not shorten or lengthen that period. The new value applies from the next period on.
- R11: `reg_rdata` shows the word addressed in the previous cycle, one register stage after `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| sys_rst | input | 1 | Synchronous active-high system reset; clears the divider, output and read register only |
| ka_rst | input | 1 | Synchronous active-high keep-alive domain reset; clears everything |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Word select: 0 source/freeze, 1 prescaler |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| slow_xtal_tick | input | 1 | Tick from the slow crystal |
| slow_rc_tick | input | 1 | Tick from the slow RC oscillator |
| fast_xtal_tick | input | 1 | Tick from the fast crystal, before division |
| rtc_ce | output | 1 | Registered clock-enable for the real-time counter |

## Verification
The bench runs every prescaler value from 2 to 31 against continuous and sparse fast ticks and counts the ticks between output pulses. A divider off by one would show up as periods of N-1 or N+1. The freeze is probed by attempting to switch the source after the first non-zero write and watching which tick stream still reaches `rtc_ce`. A lock that ignored a 0 write, or that let later writes through, would be caught the same way. A system reset is applied between writes to show the frozen state survives it, and a change of prescaler mid-period is used to catch a divider that reloads early or that keeps ticking with 0 or 1.

// File: rtl/rtcsel_pkg.sv
package rtcsel_pkg;

  typedef enum logic [1:0] {
    SRC_OFF       = 2'b00,
    SRC_SLOW_XTAL = 2'b01,
    SRC_SLOW_RC   = 2'b10,
    SRC_FAST_DIV  = 2'b11
  } src_e;

  localparam int  SRC_W    = 2;
  localparam int  N_SRC    = 4;
  localparam logic ADDR_SRC = 1'b0;
  localparam logic ADDR_DIV = 1'b1;

endpackage

// File: rtl/rtcsel_regs.sv
module rtcsel_regs
  import rtcsel_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 5
) (
  input  logic              clk,
  input  logic              sys_rst,
  input  logic              ka_rst,
  input  logic              we,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output src_e              src,
  output logic              locked,
  output logic [DIV_W-1:0]  div_val,
  output logic [DATA_W-1:0] rdata
);

  localparam int LOCK_BIT = SRC_W;

  logic [SRC_W-1:0]  wr_src;
  logic [DATA_W-1:0] rd_next;
  logic              unused_wdata_hi;

  assign wr_src          = wdata[SRC_W-1:0];
  assign unused_wdata_hi = ^wdata;

  // keep-alive domain state: untouched by the system reset
  always_ff @(posedge clk) begin
    if (ka_rst) begin
      src     <= SRC_OFF;
      locked  <= 1'b0;
      div_val <= '0;
    end else if (we) begin
      if (addr == ADDR_SRC) begin
        if (!locked) begin
          src <= src_e'(wr_src);
          if (wr_src != '0) locked <= 1'b1;
        end
      end else begin
        div_val <= wdata[DIV_W-1:0];
      end
    end
  end

  always_comb begin
    rd_next = '0;
    if (addr == ADDR_SRC) begin
      rd_next[SRC_W-1:0] = src;
      rd_next[LOCK_BIT]  = locked;
    end else begin
      rd_next[DIV_W-1:0] = div_val;
    end
  end

  always_ff @(posedge clk) begin
    if (ka_rst || sys_rst) rdata <= '0;
    else                   rdata <= rd_next;
  end

  assert_frozen_ignores_R4: assert property (@(posedge clk) disable iff (ka_rst)
    (locked && we && addr == ADDR_SRC) |=> (src == $past(src)));

  assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (ka_rst)
    locked |=> locked);

  assert_first_write_locks_R3: assert property (@(posedge clk) disable iff (ka_rst)
    (!locked && we && addr == ADDR_SRC && wr_src != '0) |=> locked);

  assert_zero_write_open_R3: assert property (@(posedge clk) disable iff (ka_rst)
    (!locked && we && addr == ADDR_SRC && wr_src == '0) |=> !locked);

  assert_sysrst_keeps_R5: assert property (@(posedge clk) disable iff (ka_rst)
    (sys_rst && !we) |=> ($stable(locked) && $stable(div_val) && $stable(src)));

  assert_ka_clears_R6: assert property (@(posedge clk)
    ka_rst |=> (!locked && div_val == '0 && src == SRC_OFF));

endmodule

// File: rtl/rtcsel_prediv.sv
module rtcsel_prediv #(
  parameter int DIV_W   = 5,
  parameter int DIV_MIN = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [DIV_W-1:0] div_val,
  output logic             pulse
);

  localparam logic [DIV_W-1:0] MIN_V = DIV_W'(DIV_MIN);
  localparam logic [DIV_W-1:0] ONE_V = DIV_W'(1);

  logic [DIV_W-1:0] cnt;
  logic             div_ok;
  logic             at_term;

  assign div_ok  = (div_val >= MIN_V);
  assign at_term = (cnt == '0);
  assign pulse   = tick && at_term && div_ok;

  // the prescaler is sampled only at terminal count
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (tick) begin
      if (at_term) cnt <= div_ok ? (div_val - ONE_V) : '0;
      else         cnt <= cnt - ONE_V;
    end
  end

  assert_count_steps_R8: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt != '0) |=> (cnt == $past(cnt) - ONE_V));

  assert_count_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));

  assert_mid_period_keeps_R10: assert property (@(posedge clk) disable iff (rst)
    (!at_term && !tick) |=> !at_term);

endmodule

// File: rtl/rtcsel_mux.sv
module rtcsel_mux
  import rtcsel_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  src_e src,
  input  logic slow_xtal_tick,
  input  logic slow_rc_tick,
  input  logic div_pulse,
  output logic ce
);

  logic [N_SRC-1:0] choice;

  generate
    for (genvar g = 0; g < N_SRC; g++) begin : g_choice
      if (g == int'(SRC_SLOW_XTAL)) begin : g_xt
        assign choice[g] = slow_xtal_tick;
      end else if (g == int'(SRC_SLOW_RC)) begin : g_rc
        assign choice[g] = slow_rc_tick;
      end else if (g == int'(SRC_FAST_DIV)) begin : g_fd
        assign choice[g] = div_pulse;
      end else begin : g_off
        assign choice[g] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) ce <= 1'b0;
    else     ce <= choice[src];
  end

  assert_off_silent_R2: assert property (@(posedge clk) disable iff (rst)
    (src == SRC_OFF) |=> !ce);

  assert_xtal_route_R2: assert property (@(posedge clk) disable iff (rst)
    (src == SRC_SLOW_XTAL) |=> (ce == $past(slow_xtal_tick)));

  assert_rc_route_R2: assert property (@(posedge clk) disable iff (rst)
    (src == SRC_SLOW_RC) |=> (ce == $past(slow_rc_tick)));

endmodule

// File: rtl/rtc_src_select.sv
module rtc_src_select
  import rtcsel_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int DIV_W   = 5,
  parameter int DIV_MIN = 2
) (
  input  logic              clk,
  input  logic              sys_rst,
  input  logic              ka_rst,
  input  logic              reg_we,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              slow_xtal_tick,
  input  logic              slow_rc_tick,
  input  logic              fast_xtal_tick,
  output logic              rtc_ce
);

  localparam logic [DIV_W-1:0] MIN_V = DIV_W'(DIV_MIN);

  src_e             src;
  logic             locked;
  logic [DIV_W-1:0] div_val;
  logic             div_pulse;
  logic             run_rst;

  assign run_rst = sys_rst || ka_rst;

  rtcsel_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_regs (
    .clk     (clk),
    .sys_rst (sys_rst),
    .ka_rst  (ka_rst),
    .we      (reg_we),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .src     (src),
    .locked  (locked),
    .div_val (div_val),
    .rdata   (reg_rdata)
  );

  rtcsel_prediv #(.DIV_W(DIV_W), .DIV_MIN(DIV_MIN)) u_div (
    .clk     (clk),
    .rst     (run_rst),
    .tick    (fast_xtal_tick),
    .div_val (div_val),
    .pulse   (div_pulse)
  );

  rtcsel_mux u_mux (
    .clk            (clk),
    .rst            (run_rst),
    .src            (src),
    .slow_xtal_tick (slow_xtal_tick),
    .slow_rc_tick   (slow_rc_tick),
    .div_pulse      (div_pulse),
    .ce             (rtc_ce)
  );

  assert_short_div_silent_R9: assert property (@(posedge clk) disable iff (run_rst)
    (div_val < MIN_V) |=> !rtc_ce || $past(src != SRC_FAST_DIV));

  assert_ce_needs_source_R2: assert property (@(posedge clk) disable iff (run_rst)
    rtc_ce |-> $past(src != SRC_OFF));

endmodule

// File: tb/sim_rtc_src_select.sv
module sim_rtc_src_select;

  logic       clk = 1'b0;
  logic       sys_rst = 1'b1;
  logic       ka_rst = 1'b1;
  logic       reg_we = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       slow_xtal_tick = 1'b0;
  logic       slow_rc_tick = 1'b0;
  logic       fast_xtal_tick = 1'b0;
  logic       rtc_ce;

  int  n_total = 0;
  int  n_fail  = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  rtc_src_select u0 (
    .clk            (clk),
    .sys_rst        (sys_rst),
    .ka_rst         (ka_rst),
    .reg_we         (reg_we),
    .reg_addr       (reg_addr),
    .reg_wdata      (reg_wdata),
    .reg_rdata      (reg_rdata),
    .slow_xtal_tick (slow_xtal_tick),
    .slow_rc_tick   (slow_rc_tick),
    .fast_xtal_tick (fast_xtal_tick),
    .rtc_ce         (rtc_ce)
  );

  task automatic check(input string req, input int act, input int exp);
    n_total++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic a, input logic [7:0] d);
    @(negedge clk);
    fast_xtal_tick = 1'b0;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic read_reg(input logic a, output int v);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    v = int'(reg_rdata);
  endtask

  // source code: 0 none, 1 slow crystal, 2 slow RC
  task automatic route_check(input int sel, input string req);
    bit px = 1'b0;
    bit pr = 1'b0;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      check(req, int'(rtc_ce), sel == 1 ? int'(px) : sel == 2 ? int'(pr) : 0);
      px = (i % 3 == 0);
      pr = (i % 2 == 1);
      slow_xtal_tick = px;
      slow_rc_tick   = pr;
    end
    @(negedge clk);
    slow_xtal_tick = 1'b0;
    slow_rc_tick   = 1'b0;
  endtask

  // counts fast ticks up to and including the one that produced a pulse
  task automatic measure(input int start, input bit sparse, output int n);
    int c = start;
    bit ph = 1'b0;
    n = -1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (rtc_ce) begin
        fast_xtal_tick = 1'b0;
        n = c;
        return;
      end
      if (sparse) begin ph = ~ph; fast_xtal_tick = ph; end
      else fast_xtal_tick = 1'b1;
      if (fast_xtal_tick) c++;
    end
    fast_xtal_tick = 1'b0;
  endtask

  task automatic count_pulses(input int ticks, output int p);
    p = 0;
    for (int i = 0; i < ticks + 1; i++) begin
      @(negedge clk);
      if (rtc_ce) p++;
      fast_xtal_tick = (i < ticks);
    end
    fast_xtal_tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    int v;
    int n;
    repeat (3) @(negedge clk);
    sys_rst = 1'b0;
    ka_rst  = 1'b0;

    // R6 R11: reset state through the read port
    read_reg(1'b0, v); check("R6 word0 after reset", v, 0);
    read_reg(1'b1, v); check("R11 word1 after reset", v, 0);
    check("R2 no enable after reset", int'(rtc_ce), 0);

    // R3: writing 0 does not freeze
    write_reg(1'b0, 8'h00);
    read_reg(1'b0, v); check("R3 zero write leaves unfrozen", v, 0);
    route_check(0, "R2 code 0 silent");

    // R1 R3: first non-zero write freezes slow crystal
    write_reg(1'b0, 8'hFD);
    read_reg(1'b0, v); check("R1 freeze bit and code", v, 5);
    route_check(1, "R2 slow crystal routed");

    // R4: further writes ignored
    write_reg(1'b0, 8'h02);
    read_reg(1'b0, v); check("R4 readback unchanged", v, 5);
    route_check(1, "R4 source still slow crystal");
    write_reg(1'b0, 8'h00);
    read_reg(1'b0, v); check("R4 zero write ignored", v, 5);

    // R7: prescaler writable while frozen
    write_reg(1'b1, 8'hE7);
    read_reg(1'b1, v); check("R7 prescaler readback", v, 7);

    // R5: system reset keeps keep-alive state
    @(negedge clk); sys_rst = 1'b1;
    @(negedge clk); @(negedge clk); sys_rst = 1'b0;
    read_reg(1'b0, v); check("R5 source kept", v, 5);
    read_reg(1'b1, v); check("R5 prescaler kept", v, 7);
    route_check(1, "R5 routing kept");

    // R6: keep-alive reset clears all
    @(negedge clk); ka_rst = 1'b1;
    @(negedge clk); @(negedge clk); ka_rst = 1'b0;
    read_reg(1'b0, v); check("R6 source cleared", v, 0);
    read_reg(1'b1, v); check("R6 prescaler cleared", v, 0);
    route_check(0, "R6 output silent");

    // R2: slow RC route after unfreeze
    write_reg(1'b0, 8'h02);
    read_reg(1'b0, v); check("R1 slow RC code", v, 6);
    route_check(2, "R2 slow RC routed");

    // R8: sweep all valid prescalers on the divided source
    @(negedge clk); ka_rst = 1'b1;
    @(negedge clk); ka_rst = 1'b0;
    write_reg(1'b0, 8'h03);
    read_reg(1'b0, v); check("R1 divided code", v, 7);
    for (int d = 2; d < 32; d++) begin
      bit sp = (d % 5 == 0);
      write_reg(1'b1, 8'(d));
      measure(0, sp, n);
      measure(0, sp, n); check("R8 period first", n, d);
      measure(0, sp, n); check("R8 period second", n, d);
    end

    // R10: change mid-period
    write_reg(1'b1, 8'd10);
    measure(0, 1'b0, n);
    measure(0, 1'b0, n); check("R10 settled period", n, 10);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R10 no early pulse", int'(rtc_ce), 0);
      fast_xtal_tick = 1'b1;
    end
    write_reg(1'b1, 8'd4);
    measure(3, 1'b0, n); check("R10 old period completes", n, 10);
    measure(0, 1'b0, n); check("R10 new period applies", n, 4);

    // R9: short values are silent, recovery pulses on first tick
    write_reg(1'b1, 8'd0);
    count_pulses(80, n); check("R9 value 0 silent", n, 0);
    write_reg(1'b1, 8'd1);
    count_pulses(80, n); check("R9 value 1 silent", n, 0);
    write_reg(1'b1, 8'd5);
    measure(0, 1'b0, n); check("R9 first tick after valid", n, 1);
    measure(0, 1'b0, n); check("R8 period after recovery", n, 5);

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    finished = 1'b1;
    $finish;
  end

endmodule